// File: doc/BRIEF.md
# Rotating-Priority Arbiter with Grant Lock

This block shares one resource among four requesters. Each requester raises its bit on the request vector and keeps it high for as long as it needs the resource. When the arbiter is free, it chooses one winner on a clock edge and asserts that requester's bit on the grant vector. The grant stays with the winner for as long as its request stays high. Grant bits come only from registers, so the grant vector never reacts to the request vector within the same cycle.

When the winner lowers its request, its grant drops on the first clock edge that samples the low request. The arbiter is then idle for at least that cycle. On a later edge it chooses again, this time from the requests that are high. The search starts at the index just after the requester served last and wraps from 3 back to 0. Every requester that keeps asking is therefore served within three other tenures. A request that is withdrawn before it wins leaves no trace: the rotation changes only when a grant is issued. A winner that never releases its request keeps the resource for good, since there is no timeout or preemption.

The control pins are plain levels. There is no data path, so there is no handshake.

Top module: `rr_hold_arbiter`

## Requirements
- R1: A synchronous active-low reset clears every grant bit on the next edge. After reset, the first search begins at requester 0, so with all four requesting the first grant is 4'b0001.
- R2: The grant vector is either all zero or has exactly one bit set, in every cycle.
- R3: A grant bit is high only if the same requester's request bit was high at the clock edge that produced it.
- R4: While a granted requester keeps its request high, its grant stays high on every following edge, whatever the other requests do.
- R5: On the first edge that samples the granted requester's request low, the grant vector becomes all zero.
- R6: A new grant is issued only from the idle state. When the grant is zero and at least one request is high at an edge, exactly one grant bit is set after that edge. When no request is high, the grant stays zero.
- R7: The winner is the first requester whose request is high, scanning cyclically upward from the current start index.
- R8: Issuing a grant to requester i moves the start index to i+1, and from 3 it wraps to 0. With all four requesting and each releasing in turn, the service order is 0, 1, 2, 3, 0.
- R9: A request that rises and falls while another requester holds the grant does not change the start index.
- R10: A grant whose request never falls is held indefinitely, with no timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 4 | Request level per requester; bit i belongs to requester i |
| grant | output | 4 | Registered grant, one-hot or zero; bit i belongs to requester i |

## Verification
The assertions assume that requests are sampled levels, stable around the rising edge. They also assume that a requester lowers its request only to end its tenure or to withdraw; they do not assume that a requester waits for its grant. The bench changes requests only on the falling clock edge. It mixes directed tenures with random request patterns, in which the granted bit is held for random stretches and the other bits toggle freely. This keeps the stimulus within those assumptions while still reaching withdrawals, empty cycles and wrap-around of the start index.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
  localparam int unsigned RR_WAYS = 4;

  typedef enum logic {
    ARB_FREE = 1'b0,
    ARB_HELD = 1'b1
  } arb_state_e;
endpackage

// File: rtl/rr_rot_search.sv
module rr_rot_search #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] start,
  output logic             any,
  output logic [IDX_W-1:0] win_idx,
  output logic [N-1:0]     win_vec
);
  // scan cyclically upward from start, first hit wins
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    for (int k = 0; k < int'(N); k++) begin
      if (!any && req[(int'(start) + k) % int'(N)]) begin
        any     = 1'b1;
        win_idx = IDX_W'((int'(start) + k) % int'(N));
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign win_vec[g] = any && (win_idx == IDX_W'(g));
  end
endmodule

// File: rtl/rr_start_ptr.sv
module rr_start_ptr #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [IDX_W-1:0] win_idx,
  output logic [IDX_W-1:0] start
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      start <= '0;
    else if (issue)
      start <= (win_idx == LAST) ? '0 : win_idx + 1'b1;
  end
endmodule

// File: rtl/rr_grant_hold.sv
module rr_grant_hold
  import rr_arb_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         any,
  input  logic [N-1:0] win_vec,
  output logic         issue,
  output logic [N-1:0] grant
);
  arb_state_e   state;
  logic         release_seen;
  logic [N-1:0] grant_nxt;

  assign state        = (|grant) ? ARB_HELD : ARB_FREE;
  assign release_seen = |(grant & ~req);
  assign issue        = (state == ARB_FREE) && any;

  always_comb begin
    grant_nxt = grant;
    unique case (state)
      ARB_HELD: if (release_seen) grant_nxt = '0;
      ARB_FREE: grant_nxt = any ? win_vec : '0;
      default:  grant_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) grant <= '0;
    else        grant <= grant_nxt;
  end
endmodule

// File: rtl/rr_hold_arbiter.sv
module rr_hold_arbiter #(
  parameter int unsigned N_REQ = rr_arb_pkg::RR_WAYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] grant
);
  localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [IDX_W-1:0] start;
  logic [IDX_W-1:0] win_idx;
  logic [N_REQ-1:0] win_vec;
  logic             any;
  logic             issue;

  rr_rot_search #(.N(N_REQ), .IDX_W(IDX_W)) u_search (
    .req(req), .start(start), .any(any), .win_idx(win_idx), .win_vec(win_vec)
  );

  rr_start_ptr #(.N(N_REQ), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .issue(issue), .win_idx(win_idx), .start(start)
  );

  rr_grant_hold #(.N(N_REQ)) u_hold (
    .clk(clk), .rst_n(rst_n), .req(req), .any(any), .win_vec(win_vec),
    .issue(issue), .grant(grant)
  );
endmodule

// File: rtl/rr_arb_chk.sv
module rr_arb_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] grant
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> grant == '0);

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~$past(req)) == '0);

  // R6
  idle_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && req != '0) |=> $onehot(grant));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && req == '0) |=> grant == '0);

  for (genvar i = 0; i < N; i++) begin : g_bit
    // R4
    hold_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && req[i]) |=> grant[i]);

    // R5
    release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && !req[i]) |=> grant == '0);
  end
endmodule

bind rr_hold_arbiter rr_arb_chk #(.N(N_REQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .grant(grant)
);

// File: tb/rr_hold_arbiter_tb.sv
module rr_hold_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = 4'b0000;
  logic [3:0] grant;

  int n_chk  = 0;
  int n_fail = 0;

  // behavioural model
  int         m_cur = -1;
  int         m_start = 0;
  logic [3:0] m_grant;

  always #10 clk = ~clk;

  rr_hold_arbiter u_dut (.clk(clk), .rst_n(rst_n), .req(req), .grant(grant));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cur = -1; m_start = 0;
    end else if (m_cur >= 0) begin
      if (!req[m_cur]) m_cur = -1;
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (m_cur < 0 && req[(m_start + k) % 4]) begin
          m_cur   = (m_start + k) % 4;
          m_start = (m_cur + 1) % 4;
        end
      end
    end
  end

  always_comb m_grant = (m_cur >= 0) ? (4'b0001 << m_cur) : 4'b0000;

  // R7 R8: model compare on every cycle
  always @(negedge clk) begin
    n_chk++;
    if (grant !== m_grant) begin
      n_fail++;
      $display("FAIL R7 model compare: grant=%b expected=%b at %0t", grant, m_grant, $time);
    end
  end

  task automatic chk(input string tag, input logic [3:0] exp);
    n_chk++;
    if (grant !== exp) begin
      n_fail++;
      $display("FAIL %s grant=%b expected=%b at %0t", tag, grant, exp, $time);
    end
  endtask

  task automatic drive(input logic [3:0] v);
    req = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 4'b0000);
    rst_n = 1'b1;
    drive(4'b0000);
    chk("R1 idle after reset", 4'b0000);
    drive(4'b1111);
    chk("R1 first search at 0", 4'b0001);
    repeat (3) @(negedge clk);
    chk("R4 hold while requesting", 4'b0001);
    drive(4'b1110);
    chk("R5 drop on release", 4'b0000);
    chk("R6 no same-edge regrant", 4'b0000);
    @(negedge clk);
    chk("R8 next after 0", 4'b0010);
    drive(4'b1100); chk("R5 drop 1", 4'b0000);
    @(negedge clk); chk("R8 next after 1", 4'b0100);
    drive(4'b1000); chk("R5 drop 2", 4'b0000);
    @(negedge clk); chk("R8 next after 2", 4'b1000);
    drive(4'b0111); chk("R5 drop 3", 4'b0000);
    @(negedge clk); chk("R8 wrap to 0", 4'b0001);
    // R9: requester 1 withdraws before being served
    drive(4'b0011); chk("R4 hold with newcomer", 4'b0001);
    drive(4'b0001);
    drive(4'b0100); chk("R5 drop 0", 4'b0000);
    @(negedge clk); chk("R9 withdrawn skipped, 2 wins", 4'b0100);
    // R10: never released
    req = 4'b1111;
    repeat (400) @(negedge clk);
    chk("R10 indefinite hold", 4'b0100);
    drive(4'b0011); chk("R5 drop after long hold", 4'b0000);
    @(negedge clk); chk("R7 search 3 then 0", 4'b0001);
    // random phase with mid-run reset
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] r;
      r = $urandom;
      if (c == 1500) rst_n = 1'b0;
      if (c == 1503) rst_n = 1'b1;
      req = r[3:0];
      if (grant != 4'b0000 && r[7:5] != 3'b000) req = req | grant;
      @(negedge clk);
      if (c == 1502) chk("R1 mid-run reset", 4'b0000);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired grant=%b expected=done", grant);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule